// File: doc/BRIEF.md
# Multimode State-Variable Filter and Output Mixer

This block is a fixed-point model of the analog filter and output mixer of a three-voice sound generator. On every sample strobe it takes three signed voice samples and one external sample. A routing byte decides, for each source, whether it feeds the filter or goes straight to the mixer. The filter is a loop made of a summer and two integrators. It keeps a highpass, a bandpass and a lowpass state. Any mix of these three states can be added to the direct-path sum. A volume stage then scales the total into one signed 16-bit sample.

Software configures the block through one 16-bit write. The low byte holds the routing bits and the resonance. The high byte holds the voice-3 direct mute, the three response enables and the volume. The cutoff is an 11-bit coefficient input that sets the gain of both integrators. All arithmetic clamps at its width and never wraps.

Top module: `svf_mixer`

## Requirements
- R1: While reset is low, and after it, `out_sample` is 0, `out_valid` is 0, both configuration bytes are 0 and all three filter states are 0. With the reset configuration (volume 0), every sample produces an output of 0.
- R2: Routing bit k (bit 0 voice 1, bit 1 voice 2, bit 2 voice 3, bit 3 external) sends that source to the filter-input sum when it is 1, or to the direct sum when it is 0. No source is counted in both sums.
- R3: Mode bit 7 removes voice 3 from the direct sum only. When routing bit 2 is 1, voice 3 reaches the filter input whatever the value of mode bit 7.
- R4: The resonance field is routing bits 7:4. The bandpass feedback term is bandpass × (16 − resonance) >>> 3, so the feedback multiplier is the complement of the field plus one, in eighths.
- R5: Mode bits 6, 5 and 4 add the new highpass, bandpass and lowpass states, respectively, to the direct sum. The result is clamped to 20 bits.
- R6: On each sample the lowpass state becomes lp + (cutoff × old bp) >>> 16. The bandpass state then becomes bp + (cutoff × old hp) >>> 16. The highpass state becomes −(feedback term + new lp + filter-input sum). All three results are clamped to signed 20 bits.
- R7: Mode bits 3:0 set the volume v. The scaled value is (mix × v × 4369) >>> 16, which is mix × v/15 with a reciprocal constant.
- R8: The volume-stage level is offset-binary around 2^15 and clamped to 0..65535. The output is that level minus 2^15, so it is the scaled value clamped to −32768..32767.
- R9: The filter states and `out_sample` change only on a clock edge where `smp_valid` is 1. `out_valid` is a copy of `smp_valid` delayed by one cycle.
- R10: When `cfg_we` is 1, `cfg_data[7:0]` is loaded into the routing byte and `cfg_data[15:8]` into the mode byte. A sample taken on the same edge still uses the old bytes.
- R11: Each voice sample is shifted arithmetically right by 2 and offset by +256 before routing. The external sample is shifted right by 2 and gets no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Low byte: routing and resonance; high byte: mute, enables and volume |
| smp_valid | input | 1 | Advances the filter by one sample |
| voice1_in | input | 16 | Signed voice 1 sample |
| voice2_in | input | 16 | Signed voice 2 sample |
| voice3_in | input | 16 | Signed voice 3 sample |
| ext_in | input | 16 | Signed external sample |
| cutoff | input | 11 | Unsigned integrator coefficient |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed mixed output sample |

## Verification
The three filter states can only be seen through the mixer. A wrong lowpass or bandpass value reaches `out_sample` on the very next strobe if its enable bit is set. Through the feedback loop it also corrupts the highpass state on that same strobe, and the other states one or two strobes later. If a state is enabled only after the error, the fault still shows at the first sample after that enable. For this reason the reference model is compared on every clock under several mode masks, so that a divergence in ordering, clamping or resonance gain is caught within a few samples of its cause.

// File: rtl/svf_pkg.sv
package svf_pkg;

   // routing byte: resonance in 7:4, per-source filter select in 3:0
   typedef struct packed {
      logic [3:0] res;
      logic [3:0] to_filt;
   } svf_route_t;

   // mode byte: voice-3 direct mute, response enables, volume
   typedef struct packed {
      logic       mute3;
      logic       hp_en;
      logic       bp_en;
      logic       lp_en;
      logic [3:0] vol;
   } svf_mode_t;

   localparam int SVF_SRC_N = 4;
   localparam int SVF_VOICE_N = 3;

endpackage

// File: rtl/svf_sat.sv
module svf_sat #(
   parameter int IN_W  = 24,
   parameter int OUT_W = 20
) (
   input  logic signed [IN_W-1:0]  d,
   output logic signed [OUT_W-1:0] q
);
   initial begin
      assert (IN_W >= OUT_W) else $error("svf_sat: IN_W below OUT_W");
   end

   generate
      if (IN_W == OUT_W) begin : g_pass
         assign q = d;
      end else begin : g_clamp
         localparam logic signed [IN_W-1:0] HI =
            {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
         localparam logic signed [IN_W-1:0] LO =
            {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
         always_comb begin
            if (d > HI)      q = HI[OUT_W-1:0];
            else if (d < LO) q = LO[OUT_W-1:0];
            else             q = d[OUT_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/svf_integrator.sv
module svf_integrator #(
   parameter int STATE_W    = 20,
   parameter int COEF_W     = 11,
   parameter int COEF_SHIFT = 16
) (
   input  logic signed [STATE_W-1:0] state,
   input  logic signed [STATE_W-1:0] drive,
   input  logic        [COEF_W-1:0]  coef,
   output logic signed [STATE_W-1:0] next
);
   localparam int PW = STATE_W + COEF_W + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW:0]   acc;

   always_comb begin
      prod = $signed({1'b0, coef}) * drive;
      acc  = state + (prod >>> COEF_SHIFT);
   end

   svf_sat #(.IN_W(PW+1), .OUT_W(STATE_W)) u_sat (.d(acc), .q(next));
endmodule

// File: rtl/svf_summer.sv
module svf_summer #(
   parameter int STATE_W   = 20,
   parameter int RES_SHIFT = 3
) (
   input  logic signed [STATE_W-1:0] bp,
   input  logic signed [STATE_W-1:0] lp,
   input  logic signed [STATE_W-1:0] vin,
   input  logic        [3:0]         res,
   output logic signed [STATE_W-1:0] hp
);
   localparam int KW = STATE_W + 6;
   localparam int AW = STATE_W + 8;

   logic        [4:0]    kmul;
   logic signed [KW-1:0] kprod;
   logic signed [AW-1:0] acc;

   always_comb begin
      kmul  = 5'd16 - {1'b0, res};
      kprod = bp * $signed({1'b0, kmul});
      acc   = '0;
      acc   = acc - (kprod >>> RES_SHIFT) - lp - vin;
   end

   svf_sat #(.IN_W(AW), .OUT_W(STATE_W)) u_sat (.d(acc), .q(hp));
endmodule

// File: rtl/svf_out_stage.sv
module svf_out_stage
   import svf_pkg::*;
#(
   parameter int STATE_W   = 20,
   parameter int OUT_W     = 16,
   parameter int VOL_SHIFT = 16
) (
   input  logic signed [STATE_W-1:0] dir_sum,
   input  logic signed [STATE_W-1:0] hp,
   input  logic signed [STATE_W-1:0] bp,
   input  logic signed [STATE_W-1:0] lp,
   input  svf_mode_t                 mode,
   output logic signed [OUT_W-1:0]   out
);
   localparam int MW    = STATE_W + 3;
   localparam int GW    = STATE_W + 5 + VOL_SHIFT + 1;
   localparam int RECIP = ((1 << VOL_SHIFT) - 1) / 15;
   localparam logic [VOL_SHIFT-1:0] RECIP_V = VOL_SHIFT'(RECIP);

   logic signed [MW-1:0]      mix_acc;
   logic signed [STATE_W-1:0] mix;
   logic signed [GW-1:0]      prod;
   logic signed [GW-1:0]      scaled;

   always_comb begin
      mix_acc = dir_sum;
      if (mode.hp_en) mix_acc = mix_acc + hp;
      if (mode.bp_en) mix_acc = mix_acc + bp;
      if (mode.lp_en) mix_acc = mix_acc + lp;
   end

   svf_sat #(.IN_W(MW), .OUT_W(STATE_W)) u_mix_sat (.d(mix_acc), .q(mix));

   always_comb begin
      prod   = mix * $signed({1'b0, mode.vol}) * $signed({1'b0, RECIP_V});
      scaled = prod >>> VOL_SHIFT;
   end

   svf_sat #(.IN_W(GW), .OUT_W(OUT_W)) u_out_sat (.d(scaled), .q(out));
endmodule

// File: rtl/svf_mixer.sv
module svf_mixer
   import svf_pkg::*;
#(
   parameter int IN_W        = 16,
   parameter int STATE_W     = 20,
   parameter int COEF_W      = 11,
   parameter int COEF_SHIFT  = 16,
   parameter int VOICE_SHIFT = 2,
   parameter int VOICE_DC    = 256,
   parameter int RES_SHIFT   = 3,
   parameter int VOL_SHIFT   = 16,
   parameter int OUT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [15:0]       cfg_data,
   input  logic              smp_valid,
   input  logic [IN_W-1:0]   voice1_in,
   input  logic [IN_W-1:0]   voice2_in,
   input  logic [IN_W-1:0]   voice3_in,
   input  logic [IN_W-1:0]   ext_in,
   input  logic [COEF_W-1:0] cutoff,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_sample
);
   localparam int ACC_W = STATE_W + 2;
   localparam logic signed [STATE_W-1:0] DC_V = STATE_W'(VOICE_DC);

   initial begin
      assert (STATE_W >= IN_W + 2) else $error("svf_mixer: STATE_W too narrow");
      assert (OUT_W <= STATE_W)    else $error("svf_mixer: OUT_W wider than state");
      assert (VOICE_DC < (1 << (STATE_W - 2))) else $error("svf_mixer: VOICE_DC too large");
   end

   svf_route_t route_q;
   svf_mode_t  mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_q <= '0;
         mode_q  <= '0;
      end else if (cfg_we) begin
         route_q <= svf_route_t'(cfg_data[7:0]);
         mode_q  <= svf_mode_t'(cfg_data[15:8]);
      end
   end

   // source conditioning
   logic [IN_W-1:0]           src_raw [SVF_SRC_N];
   logic signed [STATE_W-1:0] src_s   [SVF_SRC_N];

   assign src_raw[0] = voice1_in;
   assign src_raw[1] = voice2_in;
   assign src_raw[2] = voice3_in;
   assign src_raw[3] = ext_in;

   generate
      for (genvar i = 0; i < SVF_SRC_N; i++) begin : g_src
         logic signed [STATE_W-1:0] wide;
         assign wide = {{(STATE_W-IN_W){src_raw[i][IN_W-1]}}, src_raw[i]};
         if (i < SVF_VOICE_N) begin : g_voice
            assign src_s[i] = (wide >>> VOICE_SHIFT) + DC_V;
         end else begin : g_ext
            assign src_s[i] = wide >>> VOICE_SHIFT;
         end
      end
   endgenerate

   // routing
   logic signed [ACC_W-1:0]   filt_acc, dir_acc;
   logic signed [STATE_W-1:0] filt_sum, dir_sum;

   always_comb begin
      filt_acc = '0;
      dir_acc  = '0;
      for (int k = 0; k < SVF_SRC_N; k++) begin
         if (route_q.to_filt[k])
            filt_acc = filt_acc + ACC_W'(src_s[k]);
         else if (!(k == 2 && mode_q.mute3))
            dir_acc = dir_acc + ACC_W'(src_s[k]);
      end
   end

   svf_sat #(.IN_W(ACC_W), .OUT_W(STATE_W)) u_filt_sat (.d(filt_acc), .q(filt_sum));
   svf_sat #(.IN_W(ACC_W), .OUT_W(STATE_W)) u_dir_sat  (.d(dir_acc),  .q(dir_sum));

   // filter loop
   logic signed [STATE_W-1:0] hp_q, bp_q, lp_q;
   logic signed [STATE_W-1:0] hp_nx, bp_nx, lp_nx;
   logic signed [OUT_W-1:0]   out_nx;

   svf_integrator #(.STATE_W(STATE_W), .COEF_W(COEF_W), .COEF_SHIFT(COEF_SHIFT))
      u_int_lp (.state(lp_q), .drive(bp_q), .coef(cutoff), .next(lp_nx));

   svf_integrator #(.STATE_W(STATE_W), .COEF_W(COEF_W), .COEF_SHIFT(COEF_SHIFT))
      u_int_bp (.state(bp_q), .drive(hp_q), .coef(cutoff), .next(bp_nx));

   svf_summer #(.STATE_W(STATE_W), .RES_SHIFT(RES_SHIFT))
      u_summer (.bp(bp_nx), .lp(lp_nx), .vin(filt_sum), .res(route_q.res), .hp(hp_nx));

   svf_out_stage #(.STATE_W(STATE_W), .OUT_W(OUT_W), .VOL_SHIFT(VOL_SHIFT))
      u_out (.dir_sum(dir_sum), .hp(hp_nx), .bp(bp_nx), .lp(lp_nx),
             .mode(mode_q), .out(out_nx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hp_q       <= '0;
         bp_q       <= '0;
         lp_q       <= '0;
         out_sample <= '0;
         out_valid  <= 1'b0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid) begin
            hp_q       <= hp_nx;
            bp_q       <= bp_nx;
            lp_q       <= lp_nx;
            out_sample <= out_nx;
         end
      end
   end
endmodule

// File: rtl/svf_mixer_chk.sv
module svf_mixer_chk #(
   parameter int STATE_W = 20,
   parameter int OUT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [15:0]        cfg_data,
   input logic               smp_valid,
   input logic               out_valid,
   input logic [OUT_W-1:0]   out_sample,
   input logic [7:0]         route_bits,
   input logic [7:0]         mode_bits,
   input logic [STATE_W-1:0] hp,
   input logic [STATE_W-1:0] bp,
   input logic [STATE_W-1:0] lp
);
   // R9: strobe delayed by one cycle
   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);
   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !out_valid);
   // R9: nothing moves without a strobe
   p_hold_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(out_sample) && $stable(hp) && $stable(bp) && $stable(lp)));
   // R10: configuration write and retention
   p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> ({mode_bits, route_bits} == $past(cfg_data)));
   p_cfg_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(route_bits) && $stable(mode_bits)));
   // R7: zero volume silences the output
   p_zero_vol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && mode_bits[3:0] == 4'd0) |=> (out_sample == '0));
endmodule

bind svf_mixer svf_mixer_chk #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
   .smp_valid(smp_valid), .out_valid(out_valid), .out_sample(out_sample),
   .route_bits(route_q), .mode_bits(mode_q),
   .hp(hp_q), .bp(bp_q), .lp(lp_q));

// File: tb/sim_svf_mixer.sv
module sim_svf_mixer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_data = '0;
   logic        smp_valid = 1'b0;
   logic [15:0] voice1_in = '0, voice2_in = '0, voice3_in = '0, ext_in = '0;
   logic [10:0] cutoff = '0;
   logic        out_valid;
   logic [15:0] out_sample;

   always #(CLK_PERIOD/2) clk = ~clk;

   svf_mixer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
      .smp_valid(smp_valid), .voice1_in(voice1_in), .voice2_in(voice2_in),
      .voice3_in(voice3_in), .ext_in(ext_in), .cutoff(cutoff),
      .out_valid(out_valid), .out_sample(out_sample));

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // reference state
   longint m_lp = 0, m_bp = 0, m_hp = 0, m_out = 0;
   int     m_route = 0, m_mode = 0;
   bit     m_valid = 0;

   function automatic longint clampw(longint x, int w);
      longint hi = (64'sd1 <<< (w - 1)) - 1;
      longint lo = -hi - 1;
      if (x > hi) return hi;
      if (x < lo) return lo;
      return x;
   endfunction

   task automatic model(input bit v, input int a, input int b, input int c,
                        input int e, input bit we, input int wd);
      longint src [4];
      longint fin = 0, dir = 0, mix, nlp, nbp, nhp, k;
      int res, vol;
      if (v) begin
         // R11: voice conditioning
         src[0] = (longint'(a) >>> 2) + 256;
         src[1] = (longint'(b) >>> 2) + 256;
         src[2] = (longint'(c) >>> 2) + 256;
         src[3] = longint'(e) >>> 2;
         for (int i = 0; i < 4; i++) begin
            if (m_route[i]) fin += src[i];
            else if (!(i == 2 && m_mode[7])) dir += src[i];
         end
         res = (m_route >> 4) & 15;
         nlp = clampw(m_lp + ((longint'(cutoff) * m_bp) >>> 16), 20);
         nbp = clampw(m_bp + ((longint'(cutoff) * m_hp) >>> 16), 20);
         k   = (nbp * (16 - res)) >>> 3;
         nhp = clampw(-(k + nlp + fin), 20);
         m_lp = nlp; m_bp = nbp; m_hp = nhp;
         mix = dir;
         if (m_mode[6]) mix += nhp;
         if (m_mode[5]) mix += nbp;
         if (m_mode[4]) mix += nlp;
         mix = clampw(mix, 20);
         vol = m_mode & 15;
         m_out = clampw((mix * vol * 4369) >>> 16, 16);
      end
      m_valid = v;
      if (we) begin
         m_route = wd & 8'hFF;
         m_mode  = (wd >> 8) & 8'hFF;
      end
   endtask

   task automatic check_now();
      longint got;
      got = longint'($signed(out_sample));
      checks++;
      if (out_valid !== m_valid || got != m_out) begin
         errors++;
         $display("FAIL %s: out=%0d valid=%0b expected out=%0d valid=%0b",
                  tag, got, out_valid, m_out, m_valid);
      end
   endtask

   task automatic tick(input bit v, input int a, input int b, input int c,
                       input int e, input bit we = 0, input int wd = 0);
      smp_valid = v;
      voice1_in = 16'(a); voice2_in = 16'(b); voice3_in = 16'(c); ext_in = 16'(e);
      cfg_we = we; cfg_data = 16'(wd);
      model(v, a, b, c, e, we, wd);
      @(posedge clk); #1;
      check_now();
   endtask

   task automatic cfg(input int wd);
      tick(0, 0, 0, 0, 0, 1, wd);
   endtask

   task automatic rnd_run(input int n);
      for (int i = 0; i < n; i++)
         tick(1, $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
              $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      tag = "R1"; check_now();
      rst_n = 1'b1;
      tick(1, 12000, -5000, 700, 30000);
      tick(1, -32768, 32767, 0, 100);

      // R11: conditioning on the direct path, full volume
      tag = "R11"; cfg(16'h0F00);
      tick(1, 0, 0, 0, 0);
      tick(1, 1000, -1000, 3, -7);
      tick(1, -1, -2, -3, -4);

      // R7: volume sweep
      tag = "R7";
      for (int v = 0; v < 16; v++) begin
         cfg(v << 8);
         tick(1, 20000, 5000, -3000, 1234);
         tick(1, -20000, -1, 8000, -999);
      end

      // R2: every routing combination with the lowpass on
      tag = "R2"; cutoff = 11'd900;
      for (int r = 0; r < 16; r++) begin
         cfg(16'h1F00 | r);
         rnd_run(6);
      end
      for (int r = 0; r < 16; r++) begin
         cfg(16'h0F00 | r);
         rnd_run(3);
      end

      // R3: voice-3 mute, direct and filtered
      tag = "R3";
      cfg(16'h8F00); tick(1, 0, 0, 30000, 0); tick(1, 100, 0, -30000, 0);
      cfg(16'h9F04); for (int i = 0; i < 20; i++) tick(1, 0, 0, 24000, 0);
      cfg(16'h1F04); for (int i = 0; i < 10; i++) tick(1, 0, 0, 24000, 0);

      // R4: resonance settings with bandpass output
      tag = "R4"; cutoff = 11'd1500;
      for (int r = 0; r < 16; r += 5) begin
         rst_n = 1'b0; @(posedge clk); #1;
         m_lp = 0; m_bp = 0; m_hp = 0; m_out = 0; m_valid = 0; m_route = 0; m_mode = 0;
         rst_n = 1'b1;
         cfg(16'h2F01 | (r << 4));
         tick(1, 30000, 0, 0, 0);
         for (int i = 0; i < 60; i++) tick(1, -32768, 0, 0, 0);
      end

      // R5: response masks
      tag = "R5";
      for (int m = 0; m < 8; m++) begin
         cfg(((m << 4) | 16'h0C) << 8 | 16'h83);
         rnd_run(12);
      end

      // R6: step response, slow then fast cutoff
      tag = "R6";
      cfg(16'h7F0F);
      cutoff = 11'd300;  for (int i = 0; i < 200; i++) tick(1, 16000, 16000, 16000, 16000);
      cutoff = 11'd2047; for (int i = 0; i < 200; i++) tick(1, -16000, 9000, -4000, 0);

      // R8: clamping at the extremes
      tag = "R8";
      cfg(16'h0F00);
      tick(1, 32767, 32767, 32767, 32767);
      tick(1, -32768, -32768, -32768, -32768);
      cfg(16'h7FFF); cutoff = 11'd2047;
      for (int i = 0; i < 150; i++) tick(1, 32767, 32767, 32767, 32767);
      for (int i = 0; i < 150; i++) tick(1, -32768, -32768, -32768, -32768);
      cfg(16'h7F0F);
      for (int i = 0; i < 100; i++) tick(1, (i % 2) ? 32767 : -32768, 32767, -32768, 32767);

      // R9: gaps in the strobe with moving inputs and cutoff
      tag = "R9";
      cfg(16'h7F35); cutoff = 11'd1200;
      for (int i = 0; i < 60; i++) begin
         tick(1, 9000 * (i % 3), -7000, 500, 0);
         cutoff = 11'($urandom_range(0, 2047));
         tick(0, $urandom_range(0, 65535), 77, -77, 12345);
         tick(0, -1, -1, -1, -1);
      end

      // R10: writes on a sampling edge take effect one sample later
      tag = "R10";
      tick(1, 10000, 10000, 10000, 10000, 1, 16'h0F00);
      tick(1, 10000, 10000, 10000, 10000, 1, 16'h0500);
      tick(1, 10000, 10000, 10000, 10000, 1, 16'h470F);
      tick(1, 10000, 10000, 10000, 10000);
      tick(0, 0, 0, 0, 0, 1, 16'h0000);
      tick(1, 10000, 10000, 10000, 10000);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule